// File: doc/BRIEF.md
# BASE-R Block to XGMII Lane Decoder

This block takes one descrambled 66-bit BASE-R block per transfer (a 2-bit sync header plus a 64-bit payload) and turns it into eight XGMII lanes. Each lane is an 8-bit character with a control flag. The block is classified by its sync header and, for control blocks, by the block-type byte in payload bits 7:0. The packed fields are then expanded. Each 7-bit control code becomes an XGMII control character, each 4-bit ordered-set code becomes a sequence or signal character, and start and terminate characters are placed in the lanes that the block type names.

A malformed block produces XGMII error characters. An unknown 7-bit code or an unknown ordered-set code is replaced lane by lane. A bad sync header or an unknown block type replaces all eight lanes. Descrambling, block lock, width packing and checks across blocks are done elsewhere.

Both sides use valid/ready. A block is taken on a clock edge where `in_valid` and `in_ready` are both high. Its decoded lanes appear on `out_*` from the following edge and stay there until `out_ready` is seen high with `out_valid`. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle, so full throughput is kept with no bubble. While the consumer stalls, the output is frozen and `in_ready` stays low.

Top module: `baser_blk_decoder`

## Requirements
- R1: After synchronous reset (`rst` high) `out_valid` is 0 and, with `out_ready` high, `in_ready` is 1.
- R2: An input is accepted when `in_valid` and `in_ready` are both high, and its result is presented with `out_valid` high from the next edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_data` and `out_ctrl` do not change. Results leave in the order their inputs were accepted.
- R3: Sync header value 2'b10 (data) copies `in_data` to `out_data` unchanged and clears all eight bits of `out_ctrl`. This holds whatever byte 0 contains. Lane i is `out_data[8i+7:8i]` with flag `out_ctrl[i]`.
- R4: Sync header 2'b01 (control) with block type 0x1E maps the 7-bit code at `in_data[8+7i +: 7]` to lane i and sets all flags. The mapping is 0x00→0x07, 0x06→0x06, 0x1E→0xFE, 0x2D→0x1C, 0x33→0x3C, 0x4B→0x7C, 0x55→0xBC, 0x66→0xDC and 0x78→0xF7.
- R5: A 7-bit code outside the R4 list becomes 0xFE with its flag set, in that lane only.
- R6: Type 0x78 gives lane 0 = 0xFB (control) and lanes 1–7 = payload bytes 1–7 as data.
- R7: Type 0x33 gives lanes 0–3 from codes 0–3, lane 4 = 0xFB (control) and lanes 5–7 = payload bytes 5–7 as data.
- R8: An ordered-set nibble of 0x0 gives 0x9C, 0xF gives 0x5C and any other value gives 0xFE, always with the flag set. Type 0x2D gives codes in lanes 0–3, the nibble `in_data[39:36]` in lane 4 and data in lanes 5–7. Type 0x4B gives the nibble `in_data[35:32]` in lane 0, data bytes 1–3 in lanes 1–3 and codes 4–7 in lanes 4–7.
- R9: Type 0x66 gives the ordered set from `in_data[35:32]` in lane 0, data in lanes 1–3 and 5–7, and 0xFB in lane 4. Type 0x55 gives ordered sets from `in_data[35:32]` in lane 0 and from `in_data[39:36]` in lane 4, with data in the other lanes.
- R10: Types 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1 and 0xFF mark the terminate in lanes k = 0 to 7 respectively. Lanes below k carry payload byte i+1 as data, lane k carries 0xFD (control), and lanes above k carry their 7-bit codes as in R4/R5.
- R11: A sync header of 2'b00 or 2'b11, or a control header with any other block type, gives 0xFE with the flag set on all eight lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input block present |
| in_ready | output | 1 | Decoder can take a block this cycle |
| in_hdr | input | 2 | Sync header (2'b10 data, 2'b01 control) |
| in_data | input | 64 | Descrambled payload, block type in bits 7:0 for control |
| out_valid | output | 1 | Decoded lanes present |
| out_ready | input | 1 | Consumer takes the lanes this cycle |
| out_data | output | 64 | Eight XGMII characters, lane i in bits 8i+7:8i |
| out_ctrl | output | 8 | Control flag per lane |

## Verification
A wrong block classification shows up in the very next output beat. The whole lane layout shifts, for example a start in the wrong lane, or error characters across a good block. A wrong per-lane source choice shows as a single bad character at a fixed lane. A fault in the output valid register or the ready logic is seen within one stalled cycle: a result is dropped, duplicated or changes while held. The scoreboard catches this as a count or order mismatch against the queued expected results.

// File: rtl/baser_dec_pkg.sv
package baser_dec_pkg;
  localparam int LANES = 8;
  localparam int LANE_W = 8;
  localparam int CODE_W = 7;
  localparam int DATA_W = LANES * LANE_W;

  localparam logic [1:0] SYNC_DATA = 2'b10;
  localparam logic [1:0] SYNC_CTRL = 2'b01;

  localparam logic [7:0] X_IDLE  = 8'h07;
  localparam logic [7:0] X_LPI   = 8'h06;
  localparam logic [7:0] X_START = 8'hFB;
  localparam logic [7:0] X_TERM  = 8'hFD;
  localparam logic [7:0] X_ERROR = 8'hFE;
  localparam logic [7:0] X_SEQ   = 8'h9C;
  localparam logic [7:0] X_SIG   = 8'h5C;

  typedef enum logic [3:0] {
    FMT_DATA, FMT_CTRL, FMT_OS4, FMT_S4, FMT_OSS,
    FMT_OSOS, FMT_S0, FMT_OS0, FMT_TERM, FMT_BAD
  } blk_fmt_e;

  typedef enum logic [2:0] {
    SRC_BYTE, SRC_BYTE_NEXT, SRC_CODE, SRC_START,
    SRC_TERM, SRC_OS_LO, SRC_OS_HI, SRC_ERR
  } lane_src_e;

  function automatic logic [7:0] os_char(input logic [3:0] nib);
    case (nib)
      4'h0:    os_char = X_SEQ;
      4'hF:    os_char = X_SIG;
      default: os_char = X_ERROR;
    endcase
  endfunction

  // Which field feeds a given lane for a given block layout.
  function automatic lane_src_e lane_src(input blk_fmt_e fmt, input logic [2:0] k,
                                         input int lane);
    lane_src_e s;
    case (fmt)
      FMT_DATA: s = SRC_BYTE;
      FMT_CTRL: s = SRC_CODE;
      FMT_OS4:  s = (lane < 4) ? SRC_CODE : (lane == 4) ? SRC_OS_HI : SRC_BYTE;
      FMT_S4:   s = (lane < 4) ? SRC_CODE : (lane == 4) ? SRC_START : SRC_BYTE;
      FMT_OSS:  s = (lane == 0) ? SRC_OS_LO : (lane == 4) ? SRC_START : SRC_BYTE;
      FMT_OSOS: s = (lane == 0) ? SRC_OS_LO : (lane == 4) ? SRC_OS_HI : SRC_BYTE;
      FMT_S0:   s = (lane == 0) ? SRC_START : SRC_BYTE;
      FMT_OS0:  s = (lane == 0) ? SRC_OS_LO : (lane < 4) ? SRC_BYTE : SRC_CODE;
      FMT_TERM: s = (lane < int'(k)) ? SRC_BYTE_NEXT :
                    (lane == int'(k)) ? SRC_TERM : SRC_CODE;
      default:  s = SRC_ERR;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/baser_code_xlat.sv
module baser_code_xlat
  import baser_dec_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [LANE_W-1:0] xchar
);
  always_comb begin
    case (code)
      7'h00:   xchar = X_IDLE;
      7'h06:   xchar = X_LPI;
      7'h1E:   xchar = X_ERROR;
      7'h2D:   xchar = 8'h1C;
      7'h33:   xchar = 8'h3C;
      7'h4B:   xchar = 8'h7C;
      7'h55:   xchar = 8'hBC;
      7'h66:   xchar = 8'hDC;
      7'h78:   xchar = 8'hF7;
      default: xchar = X_ERROR;
    endcase
  end
endmodule

// File: rtl/baser_blk_classify.sv
module baser_blk_classify
  import baser_dec_pkg::*;
(
  input  logic [1:0] hdr,
  input  logic [7:0] btype,
  output blk_fmt_e   fmt,
  output logic [2:0] term_k
);
  always_comb begin
    term_k = 3'd0;
    fmt    = FMT_BAD;
    if (hdr == SYNC_DATA) begin
      fmt = FMT_DATA;
    end else if (hdr == SYNC_CTRL) begin
      case (btype)
        8'h1E: fmt = FMT_CTRL;
        8'h2D: fmt = FMT_OS4;
        8'h33: fmt = FMT_S4;
        8'h66: fmt = FMT_OSS;
        8'h55: fmt = FMT_OSOS;
        8'h78: fmt = FMT_S0;
        8'h4B: fmt = FMT_OS0;
        8'h87: begin fmt = FMT_TERM; term_k = 3'd0; end
        8'h99: begin fmt = FMT_TERM; term_k = 3'd1; end
        8'hAA: begin fmt = FMT_TERM; term_k = 3'd2; end
        8'hB4: begin fmt = FMT_TERM; term_k = 3'd3; end
        8'hCC: begin fmt = FMT_TERM; term_k = 3'd4; end
        8'hD2: begin fmt = FMT_TERM; term_k = 3'd5; end
        8'hE1: begin fmt = FMT_TERM; term_k = 3'd6; end
        8'hFF: begin fmt = FMT_TERM; term_k = 3'd7; end
        default: fmt = FMT_BAD;
      endcase
    end
  end
endmodule

// File: rtl/baser_lane_build.sv
module baser_lane_build
  import baser_dec_pkg::*;
(
  input  blk_fmt_e          fmt,
  input  logic [2:0]        term_k,
  input  logic [DATA_W-1:0] payload,
  output logic [DATA_W-1:0] lane_data,
  output logic [LANES-1:0]  lane_ctrl
);
  localparam int PAD_W = DATA_W + LANE_W;
  logic [PAD_W-1:0] padded;
  assign padded = {{LANE_W{1'b0}}, payload};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int CODE_LSB = LANE_W + CODE_W * i;
    logic [CODE_W-1:0] code_f;
    logic [LANE_W-1:0] code_x;
    lane_src_e         src;

    if (CODE_LSB + CODE_W <= DATA_W) begin : g_code
      assign code_f = payload[CODE_LSB +: CODE_W];
    end else begin : g_nocode
      assign code_f = {CODE_W{1'b1}};
    end

    baser_code_xlat u_xlat (.code(code_f), .xchar(code_x));

    always_comb begin
      src = lane_src(fmt, term_k, i);
      lane_ctrl[i] = !(src == SRC_BYTE || src == SRC_BYTE_NEXT);
      case (src)
        SRC_BYTE:      lane_data[LANE_W*i +: LANE_W] = padded[LANE_W*i +: LANE_W];
        SRC_BYTE_NEXT: lane_data[LANE_W*i +: LANE_W] = padded[LANE_W*(i+1) +: LANE_W];
        SRC_CODE:      lane_data[LANE_W*i +: LANE_W] = code_x;
        SRC_START:     lane_data[LANE_W*i +: LANE_W] = X_START;
        SRC_TERM:      lane_data[LANE_W*i +: LANE_W] = X_TERM;
        SRC_OS_LO:     lane_data[LANE_W*i +: LANE_W] = os_char(payload[35:32]);
        SRC_OS_HI:     lane_data[LANE_W*i +: LANE_W] = os_char(payload[39:36]);
        default:       lane_data[LANE_W*i +: LANE_W] = X_ERROR;
      endcase
    end
  end
endmodule

// File: rtl/baser_blk_decoder.sv
module baser_blk_decoder
  import baser_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_hdr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [LANES-1:0]  out_ctrl
);
  blk_fmt_e          fmt;
  logic [2:0]        term_k;
  logic [DATA_W-1:0] dec_data;
  logic [LANES-1:0]  dec_ctrl;
  logic              take;

  baser_blk_classify u_cls (
    .hdr(in_hdr), .btype(in_data[7:0]), .fmt(fmt), .term_k(term_k)
  );

  baser_lane_build u_build (
    .fmt(fmt), .term_k(term_k), .payload(in_data),
    .lane_data(dec_data), .lane_ctrl(dec_ctrl)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_data <= dec_data;
      out_ctrl <= dec_ctrl;
    end
  end

  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  a_r2_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ctrl)));

  a_r2_accept_shows: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  a_r3_data_passes: assert property (@(posedge clk) disable iff (rst)
    (take && in_hdr == SYNC_DATA) |=> (out_ctrl == '0 && out_data == $past(in_data)));

  a_r11_bad_header: assert property (@(posedge clk) disable iff (rst)
    (take && (in_hdr == 2'b00 || in_hdr == 2'b11)) |=>
      (out_ctrl == '1 && out_data == {LANES{X_ERROR}}));
endmodule

// File: tb/test_baser_blk_decoder.sv
module test_baser_blk_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_hdr = 2'b00;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic [7:0]  out_ctrl;

  int errors = 0;
  int checks = 0;
  bit bp_en = 1'b0;
  int cyc = 0;
  bit done = 1'b0;

  logic [63:0] q_d[$];
  logic [7:0]  q_c[$];
  string       q_t[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  baser_blk_decoder i_baser_blk_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_ctrl(out_ctrl)
  );

  always @(posedge clk) begin
    cyc++;
    #2 out_ready = bp_en ? (cyc % 3 != 0) : 1'b1;
  end

  function automatic logic [7:0] xc(input logic [6:0] c);
    case (c)
      7'h00: return 8'h07;  7'h06: return 8'h06;  7'h1E: return 8'hFE;
      7'h2D: return 8'h1C;  7'h33: return 8'h3C;  7'h4B: return 8'h7C;
      7'h55: return 8'hBC;  7'h66: return 8'hDC;  7'h78: return 8'hF7;
      default: return 8'hFE;
    endcase
  endfunction

  function automatic logic [7:0] xo(input logic [3:0] n);
    return (n == 4'h0) ? 8'h9C : (n == 4'hF) ? 8'h5C : 8'hFE;
  endfunction

  function automatic logic [7:0] byt(input logic [63:0] d, input int i);
    return d[8*i +: 8];
  endfunction

  function automatic logic [6:0] cod(input logic [63:0] d, input int i);
    return d[8+7*i +: 7];
  endfunction

  // Reference model written from the requirements.
  task automatic model(input logic [1:0] h, input logic [63:0] d,
                       output logic [63:0] ed, output logic [7:0] ec);
    int k;
    ed = {8{8'hFE}}; ec = 8'hFF; k = -1;
    if (h == 2'b10) begin ed = d; ec = 8'h00; end
    else if (h == 2'b01) begin
      case (d[7:0])
        8'h87: k = 0; 8'h99: k = 1; 8'hAA: k = 2; 8'hB4: k = 3;
        8'hCC: k = 4; 8'hD2: k = 5; 8'hE1: k = 6; 8'hFF: k = 7;
        default: k = -1;
      endcase
      case (d[7:0])
        8'h1E: for (int i = 0; i < 8; i++) ed[8*i +: 8] = xc(cod(d, i));
        8'h2D, 8'h33: begin
          for (int i = 0; i < 4; i++) ed[8*i +: 8] = xc(cod(d, i));
          ed[39:32] = (d[7:0] == 8'h2D) ? xo(d[39:36]) : 8'hFB;
          ed[63:40] = d[63:40]; ec = 8'h1F;
        end
        8'h66, 8'h55: begin
          ed = d; ed[7:0] = xo(d[35:32]);
          ed[39:32] = (d[7:0] == 8'h66) ? 8'hFB : xo(d[39:36]); ec = 8'h11;
        end
        8'h78: begin ed = d; ed[7:0] = 8'hFB; ec = 8'h01; end
        8'h4B: begin
          ed[7:0] = xo(d[35:32]); ed[31:8] = d[31:8];
          for (int i = 4; i < 8; i++) ed[8*i +: 8] = xc(cod(d, i));
          ec = 8'hF1;
        end
        default: if (k >= 0) begin
          for (int i = 0; i < 8; i++) begin
            if (i < k) begin ed[8*i +: 8] = byt(d, i+1); ec[i] = 1'b0; end
            else if (i == k) ed[8*i +: 8] = 8'hFD;
            else ed[8*i +: 8] = xc(cod(d, i));
          end
        end
      endcase
    end
  endtask

  task automatic send(input logic [1:0] h, input logic [63:0] d, input string tag);
    logic [63:0] ed; logic [7:0] ec;
    model(h, d, ed, ec);
    in_valid = 1'b1; in_hdr = h; in_data = d;
    while (!in_ready) @(negedge clk);
    q_d.push_back(ed); q_c.push_back(ec); q_t.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [63:0] pk(input logic [7:0] bt, input logic [6:0] c [8]);
    logic [63:0] d = '0;
    d[7:0] = bt;
    for (int i = 0; i < 8; i++) d[8+7*i +: 7] = c[i];
    return d;
  endfunction

  // Monitor: a transfer seen at a falling edge completes at the next rising edge.
  logic        held = 1'b0;
  logic [63:0] held_d;
  logic [7:0]  held_c;
  always @(negedge clk) begin
    if (!rst) begin
      if (held) begin
        checks++;
        if (!out_valid || out_data !== held_d || out_ctrl !== held_c) begin
          errors++;
          $display("FAIL R2 stall hold: got v=%0b %h/%h expected %h/%h",
                   out_valid, out_data, out_ctrl, held_d, held_c);
        end
      end
      held = out_valid && !out_ready;
      held_d = out_data; held_c = out_ctrl;
      if (out_valid && out_ready) begin
        checks++;
        if (q_d.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected output: got %h/%h expected none", out_data, out_ctrl);
        end else begin
          logic [63:0] ed; logic [7:0] ec; string t;
          ed = q_d.pop_front(); ec = q_c.pop_front(); t = q_t.pop_front();
          if (out_data !== ed || out_ctrl !== ec) begin
            errors++;
            $display("FAIL %s: got %h/%h expected %h/%h", t, out_data, out_ctrl, ed, ec);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [6:0] c [8];
    logic [63:0] d;
    logic [63:0] lf;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset: got v=%0b r=%0b expected v=0 r=1", out_valid, in_ready);
    end

    send(2'b10, 64'h0123456789ABCDEF, "R3 data");
    send(2'b10, 64'hFFEEDDCCBBAA991E, "R3 data with 0x1E byte");
    c = '{7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00};
    send(2'b01, pk(8'h1E, c), "R4 idle");
    c = '{7'h00, 7'h06, 7'h1E, 7'h2D, 7'h33, 7'h4B, 7'h55, 7'h66};
    send(2'b01, pk(8'h1E, c), "R4 code map");
    c = '{7'h78, 7'h11, 7'h00, 7'h7F, 7'h06, 7'h01, 7'h1E, 7'h40};
    send(2'b01, pk(8'h1E, c), "R5 unknown codes");
    send(2'b01, {56'hD5D5D5D5D55555, 8'h78}, "R6 start lane 0");
    send(2'b01, {24'hAABBCC, 4'h0, 7'h06, 7'h00, 7'h1E, 7'h00, 8'h33}, "R7 start lane 4");
    send(2'b01, {24'h112233, 4'h0, 7'h00, 7'h00, 7'h00, 7'h00, 8'h2D}, "R8 os4 seq");
    send(2'b01, {24'h445566, 4'hF, 7'h00, 7'h06, 7'h00, 7'h00, 8'h2D}, "R8 os4 sig");
    send(2'b01, {24'h778899, 4'h3, 7'h00, 7'h00, 7'h00, 7'h00, 8'h2D}, "R8 os4 bad nibble");
    send(2'b01, {7'h00, 7'h2D, 7'h12, 7'h00, 4'hF, 24'h445566, 8'h4B}, "R8 os0");
    send(2'b01, {24'hD5D5D5, 4'h0, 4'h0, 24'h010203, 8'h66}, "R9 os plus start");
    send(2'b01, {24'hA1A2A3, 4'hF, 4'h0, 24'hB1B2B3, 8'h55}, "R9 double os");
    send(2'b01, {24'hA1A2A3, 4'h0, 4'h5, 24'hB1B2B3, 8'h55}, "R9 double os bad lo");
    begin
      logic [7:0] tbt [8];
      tbt = '{8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF};
      for (int k = 0; k < 8; k++) begin
        d = '0; d[7:0] = tbt[k];
        for (int j = 0; j < k; j++) d[8*(j+1) +: 8] = 8'hA0 + 8'(j);
        send(2'b01, d, $sformatf("R10 terminate lane %0d", k));
      end
      d = '0; d[7:0] = 8'hB4; d[31:8] = 24'h332211;
      d[8+7*6 +: 7] = 7'h2D; d[8+7*7 +: 7] = 7'h11;
      send(2'b01, d, "R10 terminate lane 3 with codes");
    end
    send(2'b00, 64'h0123456789ABCDEF, "R11 header 00");
    send(2'b11, 64'h0123456789ABCDEF, "R11 header 11");
    send(2'b01, 64'h0000000000000000, "R11 type 0x00");
    send(2'b01, 64'h000000000000001F, "R11 type 0x1F");

    bp_en = 1'b1;
    lf = 64'hACE1_2468_1357_BDF9;
    for (int n = 0; n < 40; n++) begin
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      if (n % 4 == 3) send(2'b01, {lf[63:8], 8'h78}, "R2 stream start");
      else send(2'b10, lf, "R2 stream data");
    end
    bp_en = 1'b0;
    repeat (10) @(negedge clk);
    checks++;
    if (q_d.size() != 0) begin
      errors++;
      $display("FAIL R2 lost results: got %0d pending expected 0", q_d.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule